// File: doc/BRIEF.md
# Triple Programmable Down-Counter Timer

The block holds three 16-bit down-counters behind an eight-address, 8-bit register port. Sixteen-bit quantities pass through two shared byte buffers. A write to an even counter address parks the high byte. The following write to the odd address of a counter commits both bytes to that counter's latch. Reading an even counter address returns the live high byte and freezes the low byte for a later read of any odd counter address. Each counter is clocked either by the system clock or by a synchronised rising edge of its own external clock input. It reloads from its latch when it expires and raises a status flag. The IRQ output follows the summary bit of the status register.

Counter 1's control register sits at offset 1. Counters 0 and 2 share offset 0, and bit 0 of counter 1's control picks which of the two a write reaches. That same bit is a global hold: setting it reloads every counter and clears all flags, and counting stays frozen while it is set. Each counter has a two-state machine. `CNT_HOLD` goes to `CNT_RUN` on the first edge after the hold bit clears (transition *release*). `CNT_RUN` goes back to `CNT_HOLD` on the first edge after the hold bit sets (transition *freeze*). A counter decrements only while it is in `CNT_RUN` and the hold bit is clear.

Top module: `tri_timer`

## Requirements
- R1: After reset every status bit is 0, `irq` is 0, the hold bit (control 1 bit 0) is 1, and every latch and count is 0xFFFF.
- R2: A write to offset 1 sets control 1. A write to offset 0 sets control 0 when control 1 bit 0 is 1, and control 2 otherwise.
- R3: Control bit 1 set makes a counter tick on every system clock. Clear makes it tick once per rising edge of its `ext_clk` bit, after a two-stage synchroniser and an edge detector.
- R4: Writing offset 2, 4 or 6 stores the MSB buffer. Writing offset 3, 5 or 7 sets the latch of counter (offset-2)/2 to {MSB buffer, data}. It also reloads that count, unless control bit 4 of that counter is 1.
- R5: A latch write clears that counter's status flag.
- R6: A control write that changes bit 1 reloads that counter from its latch.
- R7: A read of offset 1 returns the status byte. Bits 2:0 are the flags of counters 2..0, bits 6:3 are 0, and bit 7 is the OR of the flags whose control bit 6 is 1. `irq` equals bit 7.
- R8: A read of offset 2, 4 or 6 returns the high byte of the current count and saves its low byte. A read of offset 3, 5 or 7 returns the saved byte.
- R9: A counter read clears that counter's flag only if offset 1 was read while the flag was set, after the flag's most recent setting.
- R10: A 0-to-1 write of control 1 bit 0 reloads all counters and clears all flags. While the bit is 1, counts do not change except by a load. Counting resumes on the second edge after the bit is cleared.
- R11: A tick with the count at 0 reloads the count from its latch and sets the flag. Any other tick decrements the count, so a counter expires every latch+1 ticks.
- R12: A read of offset 0 returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, qualified by cs |
| wr | input | 1 | Write strobe, qualified by cs |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when not reading |
| ext_clk | input | 3 | External clock input per counter |
| irq | output | 1 | Interrupt request (status bit 7) |

## Verification
Read data is combinational, so each read is sampled within the same cycle it is driven. Register writes, flag changes and the saved low byte take effect at the edge that ends the access. An external rising edge changes the count on the third edge after the input rises. An internally clocked counter first decrements on the second edge after release. Each bench operation occupies exactly one clock edge, and inputs change 1 ns after an edge. An external pulse is held high and then low for three edges each. Every expected count is therefore an exact number of edges after its stimulus.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int N_CNT  = 3;
    localparam int ADDR_W = 3;

    // control byte fields
    localparam int CTL_HOLD_B  = 0;
    localparam int CTL_CLK_B   = 1;
    localparam int CTL_NORLD_B = 4;
    localparam int CTL_IE_B    = 6;

    typedef enum logic {
        CNT_HOLD = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;

    // R3: a detected edge is a single-cycle pulse
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tri_timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         expire
);
    cnt_state_e st_q, st_d;
    logic [W-1:0] count_q;
    logic         run_en;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CNT_HOLD: if (!hold) st_d = CNT_RUN;   // release
            CNT_RUN:  if (hold)  st_d = CNT_HOLD;  // freeze
            default:  st_d = CNT_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CNT_HOLD;
        else        st_q <= st_d;
    end

    assign run_en = (st_q == CNT_RUN) && !hold;
    assign expire = run_en && tick && (count_q == '0);
    assign count  = count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                count_q <= '1;
        else if (load)             count_q <= load_val;
        else if (expire)           count_q <= load_val;
        else if (run_en && tick)   count_q <= count_q - 1'b1;
    end

    // R10: no count change while held, except by load
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !load) |=> $stable(count_q));
    // R11: expiry reloads the latch value
    p_expire_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> (count_q == $past(load_val)));
endmodule

// File: rtl/tri_timer.sv
module tri_timer
    import tri_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_CNT-1:0]  ext_clk,
    output logic              irq
);
    logic [N_CNT-1:0]  clk_int_q, norld_q, ie_q;
    logic              hold_q;
    logic [DATA_W-1:0] msb_q, lsb_q;
    logic [CNT_W-1:0]  latch_q [N_CNT];
    logic [CNT_W-1:0]  latch_d [N_CNT];
    logic [CNT_W-1:0]  count   [N_CNT];
    logic [N_CNT-1:0]  flag_q, rsi_q, expire, ext_rise, tick, reload;
    logic [N_CNT-1:0]  latch_wr, ctl_wr, cnt_rd;
    logic [DATA_W-1:0] status;
    logic              wr_stb, rd_stb, ctl_side, hi_side, lo_side, stat_rd, irst_rise;
    logic [1:0]        sel, ctl_tgt;

    assign wr_stb    = cs & wr;
    assign rd_stb    = cs & rd;
    assign ctl_side  = (addr[2:1] == 2'd0);
    assign hi_side   = !ctl_side && !addr[0];
    assign lo_side   = !ctl_side &&  addr[0];
    assign sel       = addr[2:1] - 2'd1;
    assign ctl_tgt   = addr[0] ? 2'd1 : (hold_q ? 2'd0 : 2'd2);
    assign stat_rd   = rd_stb && (addr == 3'd1);
    assign irst_rise = wr_stb && (addr == 3'd1) && wdata[CTL_HOLD_B] && !hold_q;
    assign status    = {|(flag_q & ie_q), {(DATA_W-1-N_CNT){1'b0}}, flag_q};
    assign irq       = status[DATA_W-1];

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        assign ctl_wr[i]   = wr_stb && ctl_side && (ctl_tgt == 2'(i));
        assign latch_wr[i] = wr_stb && lo_side && (sel == 2'(i));
        assign cnt_rd[i]   = rd_stb && hi_side && (sel == 2'(i));
        assign latch_d[i]  = latch_wr[i] ? {msb_q, wdata} : latch_q[i];
        assign reload[i]   = irst_rise
                           | (latch_wr[i] & ~norld_q[i])
                           | (ctl_wr[i] & (wdata[CTL_CLK_B] ^ clk_int_q[i]));
        assign tick[i]     = clk_int_q[i] | ext_rise[i];

        tmr_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk(clk), .rst_n(rst_n), .async_in(ext_clk[i]), .rise(ext_rise[i]));

        tmr_counter #(.W(CNT_W)) i_counter (
            .clk(clk), .rst_n(rst_n), .hold(hold_q), .tick(tick[i]),
            .load(reload[i]), .load_val(latch_d[i]),
            .count(count[i]), .expire(expire[i]));

        // R11: expiry raises the flag
        p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[i] && !irst_rise) |=> flag_q[i]);
        // R5: latch write clears the flag
        p_latch_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_wr[i] && !expire[i] && !irst_rise) |=> !flag_q[i]);
        // R9: a counter read without a prior status read keeps the flag
        p_keep_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_rd[i] && flag_q[i] && !rsi_q[i] && !stat_rd && !latch_wr[i] && !irst_rise)
            |=> flag_q[i]);
    end

    // R10: internal reset clears every flag
    p_irst_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irst_rise |=> (flag_q == '0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_int_q <= '0;
            norld_q   <= '0;
            ie_q      <= '0;
            hold_q    <= 1'b1;
            msb_q     <= '0;
            lsb_q     <= '0;
            flag_q    <= '0;
            rsi_q     <= '0;
            for (int i = 0; i < N_CNT; i++) latch_q[i] <= '1;
        end else begin
            if (wr_stb && hi_side) msb_q <= wdata;
            for (int i = 0; i < N_CNT; i++) begin
                latch_q[i] <= latch_d[i];
                if (ctl_wr[i]) begin
                    clk_int_q[i] <= wdata[CTL_CLK_B];
                    norld_q[i]   <= wdata[CTL_NORLD_B];
                    ie_q[i]      <= wdata[CTL_IE_B];
                end
                if (cnt_rd[i]) lsb_q <= count[i][DATA_W-1:0];
                if (irst_rise)                                flag_q[i] <= 1'b0;
                else if (expire[i])                           flag_q[i] <= 1'b1;
                else if (latch_wr[i] || (cnt_rd[i] && rsi_q[i])) flag_q[i] <= 1'b0;
                if (expire[i])    rsi_q[i] <= 1'b0;
                else if (stat_rd) rsi_q[i] <= rsi_q[i] | flag_q[i];
            end
            if (ctl_wr[1]) hold_q <= wdata[CTL_HOLD_B];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            if (addr == 3'd1)  rdata = status;
            else if (hi_side)  rdata = count[sel][CNT_W-1:DATA_W];
            else if (lo_side)  rdata = lsb_q;
        end
    end
endmodule

// File: tb/test_tri_timer.sv
module test_tri_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] ext_clk = '0;
    logic       irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tri_timer i_tri_timer (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .irq(irq));

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        cs = 1'b1; rd = 1'b1; addr = a;
        #2 chk(req, rdata, exp);
        @(posedge clk); #1;
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            ext_clk[idx] = 1'b1; idle(3);
            ext_clk[idx] = 1'b0; idle(3);
        end
    endtask

    task automatic t_reset();
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd_chk(3'd1, 8'h00, "R1 status");
        rd_chk(3'd0, 8'h00, "R12 offset0");
        rd_chk(3'd6, 8'hFF, "R1 count2 high");
        rd_chk(3'd7, 8'hFF, "R1 count2 low");
    endtask

    task automatic t_latch();
        bus_wr(3'd2, 8'h12); bus_wr(3'd3, 8'h34);
        rd_chk(3'd2, 8'h12, "R8 R4 count0 high");
        rd_chk(3'd3, 8'h34, "R8 count0 low");
        bus_wr(3'd0, 8'h10);                      // control 0: no-reload set, R2
        bus_wr(3'd2, 8'h00); bus_wr(3'd3, 8'h55);
        rd_chk(3'd2, 8'h12, "R4 no reload high");
        rd_chk(3'd5, 8'h34, "R4 no reload low");
    endtask

    task automatic t_internal();
        bus_wr(3'd0, 8'h02);                      // internal clock: R6 reload 0x0055
        rd_chk(3'd2, 8'h00, "R6 high");
        rd_chk(3'd3, 8'h55, "R6 low");
        bus_wr(3'd1, 8'h00);                      // release
        idle(5);
        rd_chk(3'd2, 8'h00, "R3 R10 high");
        rd_chk(3'd3, 8'h51, "R3 R10 low after release");
        rd_chk(3'd6, 8'hFF, "R2 count2 untouched");
        bus_wr(3'd0, 8'h02);                      // now reaches control 2
        idle(3);
        rd_chk(3'd6, 8'hFF, "R2 count2 high");
        rd_chk(3'd7, 8'hFC, "R2 count2 runs");
        bus_wr(3'd0, 8'h00);                      // control 2 back to external
        bus_wr(3'd1, 8'h01);                      // hold
    endtask

    task automatic t_expire();
        bus_wr(3'd0, 8'h00);                      // control 0 external
        bus_wr(3'd4, 8'h00); bus_wr(3'd5, 8'h02);
        bus_wr(3'd1, 8'h40);                      // release, ie on counter 1
        idle(2);
        pulse(1, 2);
        rd_chk(3'd4, 8'h00, "R3 ext high");
        rd_chk(3'd5, 8'h00, "R3 ext two edges");
        rd_chk(3'd1, 8'h00, "R11 no flag yet");
        pulse(1, 1);
        chk("R7 irq", {7'd0, irq}, 8'h01);
        rd_chk(3'd1, 8'h82, "R7 R11 status");
        rd_chk(3'd4, 8'h00, "R11 reload high");
        rd_chk(3'd5, 8'h02, "R11 reload low");
        rd_chk(3'd1, 8'h00, "R9 cleared after status read");
        pulse(1, 3);
        rd_chk(3'd4, 8'h00, "R9 read before status");
        rd_chk(3'd1, 8'h82, "R9 flag kept");
        bus_wr(3'd4, 8'h00); bus_wr(3'd5, 8'h05);
        rd_chk(3'd1, 8'h00, "R5 latch write clears");
        rd_chk(3'd4, 8'h00, "R4 reload high");
        rd_chk(3'd5, 8'h05, "R4 reload low");
    endtask

    task automatic t_mask_and_reset();
        bus_wr(3'd1, 8'h00);                      // ie off
        idle(2);
        pulse(1, 6);
        chk("R7 masked irq", {7'd0, irq}, 8'h00);
        rd_chk(3'd0, 8'h00, "R12 offset0 read");
        rd_chk(3'd1, 8'h02, "R7 R12 masked status");
        pulse(1, 1);
        rd_chk(3'd4, 8'h00, "R3 high");
        rd_chk(3'd5, 8'h04, "R3 one edge");
        bus_wr(3'd1, 8'h01);                      // internal reset
        rd_chk(3'd1, 8'h00, "R10 status cleared");
        rd_chk(3'd4, 8'h00, "R10 reload high");
        rd_chk(3'd5, 8'h05, "R10 reload low");
        pulse(1, 2);
        rd_chk(3'd4, 8'h00, "R10 held high");
        rd_chk(3'd5, 8'h05, "R10 held low");
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_latch();
        t_internal();
        t_expire();
        t_mask_and_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule